// File: doc/BRIEF.md
# Periodic Wake-up Interrupt Timer

This block counts ticks of a slow time base (normally a 32.768 kHz clock, reduced to a one-cycle enable pulse in the system clock domain). When the count reaches a programmed 32-bit period, it raises an interrupt and wake-up request. Software programs it over a simple synchronous byte-wide register port. The period is loaded one byte at a time. The three upper bytes only stage a value. Writing the least significant byte commits all 32 bits together and restarts the count from zero. The resulting interval is period / 32768 seconds when the tick comes from a 32.768 kHz source.

The running count is visible in four byte registers. Reading the least significant count byte captures the whole counter at that instant. The other three bytes are then read from that capture, so a multi-byte read cannot mix two different count values. A control register holds the interrupt enable and a write-one-to-clear bit for the pending flag, and it also shows the pending flag.

Top module: `wakeTimer`

## Requirements
- R1: After reset, the active period, the staged bytes, the counter, the capture register, the pending flag and the enable are all zero. irqOut is low and every register reads as 0x00.
- R2: Writes to addresses 0x0, 0x1 and 0x2 (period bytes 3, 2 and 1, with 0x0 the most significant) only stage data. They do not change the period in use.
- R3: A write to address 0x3 loads {byte at 0x0, byte at 0x1, byte at 0x2, written data} as the active period and clears the counter to zero, even if a tick arrives in the same cycle.
- R4: With a non-zero period P, each tickEn pulse adds one to the counter. The P-th tick after a commit or after the previous match returns the counter to zero and sets the pending flag. For P = 1 this happens on every tick.
- R5: With an active period of zero, the counter does not move and the pending flag is never set.
- R6: A read of address 0x7 returns the live counter bits [7:0] and captures all 32 counter bits at the same time. Reads of 0x4, 0x5 and 0x6 return capture bits [31:24], [23:16] and [15:8].
- R7: The control register is at 0x8. Bit 0 is the read/write interrupt enable. Writing 1 to bit 1 clears the pending flag, writing 0 to it has no effect, and bit 1 always reads 0. Bit 2 reads the pending flag. irqOut is high exactly when the flag and the enable are both 1.
- R8: The pending flag stays set while the enable is 0, and only a clear write removes it.
- R9: If a match and a clear write fall in the same cycle, the flag ends set.
- R10: Read data appears on regRdata on the clock edge that samples regRd. Period addresses 0x0 to 0x3 and unmapped addresses read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle time-base tick that advances the counter |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, registered |
| irqOut | output | 1 | Interrupt / wake-up request |

## Verification
The bench stages upper period bytes while a short period is running and checks that the event rate does not change. A design that loads each byte as it arrives would stop firing at the old rate. It reads the count bytes far apart in time with a byte boundary crossed in between, so a design that reads the live counter for the upper bytes would return a torn value. It issues a tick in the same cycle as a commit, and a clear in the same cycle as a match. The wrong outcome in those two cases is a counter left at one, or an event that is lost. Period one and period zero check that a match occurs on every tick and that the counter is frozen, respectively.

// File: rtl/wakeTimerPkg.sv
package wakeTimerPkg;
  // byte index inside the staged period; the block supports up to 8 bytes
  typedef logic [2:0] byteIdx_t;

  typedef struct packed {
    logic     stageWr;     // store write data into one upper staging byte
    byteIdx_t stageIdx;    // which staging byte (0 = most significant)
    logic     commitWr;    // least significant period byte written
    logic     snapCapture; // least significant count byte read
  } tmrStrobes_t;
endpackage

// File: rtl/wakeTimerCtrl.sv
module wakeTimerCtrl
  import wakeTimerPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        ctrlWdata,
  input  logic              matchPulse,
  input  logic [CNT_W-1:0]  snapshot,
  input  logic [DATA_W-1:0] liveLsb,
  output tmrStrobes_t       strobes,
  output logic [DATA_W-1:0] regRdata,
  output logic              flagPending,
  output logic              irqOut
);
  localparam int BYTES    = CNT_W / DATA_W;
  localparam int PER_LSB  = BYTES - 1;
  localparam int CNT_BASE = BYTES;
  localparam int CNT_LSB  = 2 * BYTES - 1;
  localparam int CTRL_AD  = 2 * BYTES;

  logic irqEnable;
  logic ctrlWr;
  logic [DATA_W-1:0] rdNext;

  // address decode into datapath strobes
  always_comb begin
    strobes = '0;
    if (regWr && (regAddr < ADDR_W'(PER_LSB))) begin
      strobes.stageWr  = 1'b1;
      strobes.stageIdx = byteIdx_t'(regAddr);
    end
    strobes.commitWr    = regWr && (regAddr == ADDR_W'(PER_LSB));
    strobes.snapCapture = regRd && (regAddr == ADDR_W'(CNT_LSB));
  end

  assign ctrlWr = regWr && (regAddr == ADDR_W'(CTRL_AD));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnable   <= 1'b0;
      flagPending <= 1'b0;
    end else begin
      if (ctrlWr) irqEnable <= ctrlWdata[0];
      // a new match outranks a clear in the same cycle
      if (matchPulse)                 flagPending <= 1'b1;
      else if (ctrlWr && ctrlWdata[1]) flagPending <= 1'b0;
    end
  end

  assign irqOut = flagPending & irqEnable;

  // read multiplexer
  always_comb begin
    rdNext = '0;
    for (int b = 0; b < BYTES - 1; b++) begin
      if (regAddr == ADDR_W'(CNT_BASE + b))
        rdNext = snapshot[(BYTES-1-b)*DATA_W +: DATA_W];
    end
    if (regAddr == ADDR_W'(CNT_LSB))
      rdNext = liveLsb;
    else if (regAddr == ADDR_W'(CTRL_AD))
      rdNext = DATA_W'({flagPending, 1'b0, irqEnable});
  end

  always_ff @(posedge clk) begin
    if (!rstN)      regRdata <= '0;
    else if (regRd) regRdata <= rdNext;
  end
endmodule

// File: rtl/wakeTimerDp.sv
module wakeTimerDp
  import wakeTimerPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tmrStrobes_t       strobes,
  input  logic [DATA_W-1:0] regWdata,
  output logic [CNT_W-1:0]  activePeriod,
  output logic [CNT_W-1:0]  liveCount,
  output logic [CNT_W-1:0]  snapshot,
  output logic              matchPulse
);
  localparam int BYTES  = CNT_W / DATA_W;
  localparam int UPPER  = BYTES - 1;
  localparam int UP_W   = UPPER * DATA_W;

  logic [DATA_W-1:0] stageByte [UPPER];
  logic [UP_W-1:0]   stagedUpper;
  logic [CNT_W-1:0]  countNext;
  logic              running;
  logic              hit;

  // one staging register per upper byte, index 0 is most significant
  for (genvar g = 0; g < UPPER; g++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN)
        stageByte[g] <= '0;
      else if (strobes.stageWr && strobes.stageIdx == byteIdx_t'(g))
        stageByte[g] <= regWdata;
    end
    assign stagedUpper[(UPPER-1-g)*DATA_W +: DATA_W] = stageByte[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 activePeriod <= '0;
    else if (strobes.commitWr) activePeriod <= {stagedUpper, regWdata};
  end

  assign running   = (activePeriod != '0);
  assign countNext = liveCount + 1'b1;
  assign hit       = tickEn && running && (countNext == activePeriod);
  assign matchPulse = hit && !strobes.commitWr;

  always_ff @(posedge clk) begin
    if (!rstN)                   liveCount <= '0;
    else if (strobes.commitWr)   liveCount <= '0;
    else if (tickEn && running)  liveCount <= hit ? '0 : countNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    snapshot <= '0;
    else if (strobes.snapCapture) snapshot <= liveCount;
  end
endmodule

// File: rtl/wakeTimer.sv
module wakeTimer
  import wakeTimerPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  tmrStrobes_t      strobes;
  logic [CNT_W-1:0] activePeriod;
  logic [CNT_W-1:0] liveCount;
  logic [CNT_W-1:0] snapshot;
  logic             matchPulse;
  logic             flagPending;

  wakeTimerCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regRd      (regRd),
    .regAddr    (regAddr),
    .ctrlWdata  (regWdata[1:0]),
    .matchPulse (matchPulse),
    .snapshot   (snapshot),
    .liveLsb    (liveCount[DATA_W-1:0]),
    .strobes    (strobes),
    .regRdata   (regRdata),
    .flagPending(flagPending),
    .irqOut     (irqOut)
  );

  wakeTimerDp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .strobes     (strobes),
    .regWdata    (regWdata),
    .activePeriod(activePeriod),
    .liveCount   (liveCount),
    .snapshot    (snapshot),
    .matchPulse  (matchPulse)
  );
endmodule

// File: rtl/wakeTimerChecker.sv
module wakeTimerChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic              clearBit,
  input logic [DATA_W-1:0] regRdata,
  input logic [CNT_W-1:0]  activePeriod,
  input logic [CNT_W-1:0]  liveCount,
  input logic              flagPending,
  input logic              matchPulse
);
  localparam int BYTES   = CNT_W / DATA_W;
  localparam int PER_LSB = BYTES - 1;
  localparam int CTRL_AD = 2 * BYTES;

  logic commitWr;
  logic clearWr;
  assign commitWr = regWr && (regAddr == ADDR_W'(PER_LSB));
  assign clearWr  = regWr && (regAddr == ADDR_W'(CTRL_AD)) && clearBit;

  AST_COMMIT_ZEROES_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    commitWr |=> (liveCount == '0)); // R3
  AST_COUNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (activePeriod != '0) |-> (liveCount < activePeriod)); // R4
  AST_ZERO_PERIOD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    ((activePeriod == '0) && !commitWr) |=> ($stable(liveCount) && !$rose(flagPending))); // R5
  AST_CLEAR_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regAddr == ADDR_W'(CTRL_AD)) |=> !regRdata[1]); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flagPending && !clearWr) |=> flagPending); // R8
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> flagPending); // R9
endmodule

bind wakeTimer wakeTimerChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .regWr       (regWr),
  .regRd       (regRd),
  .regAddr     (regAddr),
  .clearBit    (regWdata[1]),
  .regRdata    (regRdata),
  .activePeriod(activePeriod),
  .liveCount   (liveCount),
  .flagPending (flagPending),
  .matchPulse  (matchPulse)
);

// File: tb/test_wakeTimer.sv
`timescale 1ns/1ps
module test_wakeTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       irqOut;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  wakeTimer i_wakeTimer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic busWriteTick(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regWr = 1'b1; regAddr = a; regWdata = d; tickEn = 1'b1;
    @(negedge clk); regWr = 1'b0; tickEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regRd = 1'b1; regAddr = a;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic setPeriod(input logic [31:0] p);
    busWrite(4'h0, p[31:24]);
    busWrite(4'h1, p[23:16]);
    busWrite(4'h2, p[15:8]);
    busWrite(4'h3, p[7:0]);
  endtask

  task automatic expectCtrl(input string req, input logic [7:0] exp);
    logic [7:0] d;
    busRead(4'h8, d);
    check(req, d, exp);
  endtask

  task automatic tReset();
    logic [7:0] d;
    check("R1 irqOut", irqOut, 1'b0);
    for (int a = 0; a <= 8; a++) begin
      busRead(4'(a), d);
      check("R1 reset read", d, 8'h00);
    end
  endtask

  task automatic tBasic();
    logic [7:0] d;
    setPeriod(32'd3);
    busWrite(4'h8, 8'h01);
    ticks(2);
    expectCtrl("R4 no flag before P", 8'h01);
    ticks(1);
    expectCtrl("R4 flag at P", 8'h05);
    check("R7 irq enabled+pending", irqOut, 1'b1);
    busRead(4'h7, d);
    check("R4 count wraps to 0", d, 8'h00);
    busRead(4'h3, d);
    check("R10 period byte reads 0", d, 8'h00);
  endtask

  task automatic tClear();
    busWrite(4'h8, 8'h01);
    expectCtrl("R7 write 0 to clear no effect", 8'h05);
    busWrite(4'h8, 8'h03);
    expectCtrl("R7 clear flag, bit1 reads 0", 8'h01);
    check("R7 irq low after clear", irqOut, 1'b0);
  endtask

  task automatic tSticky();
    ticks(3);
    busWrite(4'h8, 8'h00);
    check("R8 irq gated off", irqOut, 1'b0);
    expectCtrl("R8 flag stays while disabled", 8'h04);
    busWrite(4'h8, 8'h01);
    check("R7 irq back on", irqOut, 1'b1);
    busWrite(4'h8, 8'h03);
  endtask

  task automatic tStaging();
    logic [7:0] d;
    busWrite(4'h0, 8'h01);
    busWrite(4'h1, 8'h00);
    busWrite(4'h2, 8'h00);
    ticks(3);
    expectCtrl("R2 staged bytes keep old period", 8'h05);
    busWrite(4'h8, 8'h03);
    busWrite(4'h3, 8'h00);
    ticks(5);
    busRead(4'h7, d);
    check("R3 committed staged period count", d, 8'd5);
    expectCtrl("R3 large period no flag", 8'h01);
    busRead(4'h4, d);
    check("R6 snapshot MSB", d, 8'h00);
  endtask

  task automatic tSnapshot();
    logic [7:0] d;
    setPeriod(32'h0000_1000);
    ticks(300);
    busRead(4'h7, d);
    check("R6 live LSB at 300", d, 8'h2C);
    ticks(300);
    busRead(4'h6, d);
    check("R6 byte1 from snapshot", d, 8'h01);
    busRead(4'h5, d);
    check("R6 byte2 from snapshot", d, 8'h00);
    busRead(4'h7, d);
    check("R6 live LSB at 600", d, 8'h58);
    busRead(4'h6, d);
    check("R6 byte1 new snapshot", d, 8'h02);
  endtask

  task automatic tRestart();
    logic [7:0] d;
    setPeriod(32'd5);
    ticks(3);
    busWrite(4'h3, 8'd5);
    busRead(4'h7, d);
    check("R3 rewrite LSB restarts count", d, 8'h00);
    ticks(4);
    expectCtrl("R3 no flag 4 ticks after restart", 8'h01);
    ticks(1);
    expectCtrl("R4 flag 5 ticks after restart", 8'h05);
    busWrite(4'h8, 8'h03);
    ticks(2);
    busWriteTick(4'h3, 8'd5);
    busRead(4'h7, d);
    check("R3 commit beats same-cycle tick", d, 8'h00);
  endtask

  task automatic tZero();
    logic [7:0] d;
    setPeriod(32'd0);
    ticks(10);
    busRead(4'h7, d);
    check("R5 zero period count frozen", d, 8'h00);
    expectCtrl("R5 zero period no flag", 8'h01);
  endtask

  task automatic tRace();
    setPeriod(32'd2);
    ticks(1);
    busWriteTick(4'h8, 8'h03);
    expectCtrl("R9 match beats clear", 8'h05);
    busWrite(4'h8, 8'h03);
    expectCtrl("R9 later clear works", 8'h01);
  endtask

  task automatic tPeriodOne();
    logic [7:0] d;
    setPeriod(32'd1);
    ticks(1);
    expectCtrl("R4 period one fires each tick", 8'h05);
    busWrite(4'h8, 8'h03);
    ticks(1);
    expectCtrl("R4 period one fires again", 8'h05);
    busRead(4'hF, d);
    check("R10 unmapped reads 0", d, 8'h00);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tClear();
    tSticky();
    tStaging();
    tSnapshot();
    tRestart();
    tZero();
    tRace();
    tPeriodOne();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule